// File: doc/BRIEF.md
# Six-Mode Programmable Interval Counter

This block is a single 16-bit timer channel. Software first writes a control word that picks one of six operating modes and a binary or decimal (BCD) count format. It then writes an initial count. The channel counts down once per `clk` cycle. A `gate` input enables counting, pauses it or triggers it, depending on the mode. The `out` pin gives the waveform for the selected mode: a level change at terminal count, a retriggerable one-shot, a rate pulse, a square wave or a one-cycle strobe.

The whole channel is synchronous to `clk`. A control word or count write is a one-cycle strobe that is sampled on the rising edge. The `gate` input must be synchronous to `clk`. A trigger is a low-to-high change between two successive samples. It is held for exactly one cycle, so a one-cycle-high pulse on `gate` is always caught.

Top module: `pit_channel`

## Requirements
- R1: After reset, `out` is low and stays low until a control word and a count have been written, whatever `gate` does.
- R2: In the cycle of a control-word write, all counting state is cleared and any unloaded count is discarded. `out` is low from the next cycle for mode 0 and high for every other mode. `ctrl_mode` values 0 to 5 select modes 0 to 5, 6 selects mode 2 and 7 selects mode 3. `ctrl_bcd`=1 selects four-digit BCD counting.
- R3: A written count is loaded into the counter on the next edge in modes 0, 2, 3 and 4, and on a gate trigger in modes 1 and 5. A count of 0 stands for 65536 (binary) or 10000 (BCD) cycles.
- R4: In modes 0, 2, 3 and 4 a low `gate` holds the counter still. In modes 1 and 5 the `gate` level has no effect. A trigger is a rising `gate` seen between two samples, and it lasts exactly one cycle.
- R5: Mode 0: `out` goes low on a count write and goes high N cycles after the load (terminal count). It then stays high while the counter keeps wrapping.
- R6: Mode 1: a trigger loads N and drives `out` low from the next cycle. `out` returns high when the count reaches zero. A trigger during the pulse restarts the N-cycle pulse.
- R7: Mode 2: with period N, `out` is low for one cycle in every N. The counter reloads N itself after reaching 1.
- R8: Mode 3: with period N, `out` is high for ceil(N/2) cycles and low for floor(N/2) cycles, repeating.
- R9: Modes 4 and 5: `out` pulses low for exactly one cycle, N cycles after the load. There is only one pulse per load, even though the counter wraps afterwards.
- R10: Modes 2 and 3: a low `gate` forces `out` high at once, with no clock edge needed. A trigger reloads N and restarts the period.
- R11: In BCD mode each nibble counts as a decimal digit and borrows from 0 to 9. The periods therefore follow the decimal value of the count (for example, 0x12 gives 12 cycles).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each rising edge is one count step |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control-word write strobe |
| ctrl_mode | input | 3 | Mode field of the control word |
| ctrl_bcd | input | 1 | 1 = BCD counting, 0 = binary |
| cnt_we | input | 1 | Initial-count write strobe |
| cnt_data | input | 16 | Initial count value |
| gate | input | 1 | Gate input, synchronous to clk |
| out | output | 1 | Channel output waveform |

## Verification
The only visible output is `out`, so every kind of internal fault shows up as an edge in the wrong cycle. A wrong borrow in the BCD decrement stretches or shortens a period from the first cycle of the affected digit. A missed reload shows within one period as a strobe that never repeats. A lost or doubled trigger moves the one-shot edge by one or more cycles. The bench compares `out` against an independent integer model on every cycle, so a divergence is reported in the cycle where it first appears.

// File: rtl/pit_pkg.sv
package pit_pkg;

    typedef enum logic [2:0] {
        M_TERM     = 3'd0,
        M_ONESHOT  = 3'd1,
        M_RATE     = 3'd2,
        M_SQUARE   = 3'd3,
        M_SWSTROBE = 3'd4,
        M_HWSTROBE = 3'd5
    } mode_e;

    // Codes 6 and 7 alias the two periodic modes.
    function automatic mode_e norm_mode(input logic [2:0] raw);
        return raw[1] ? mode_e'({1'b0, raw[1:0]}) : mode_e'(raw);
    endfunction

endpackage

// File: rtl/pit_gate_unit.sv
module pit_gate_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    output logic trig
);
    logic gate_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate;
    end

    assign trig = gate & ~gate_q;

    AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !trig); // R4
endmodule

// File: rtl/pit_dec_unit.sv
module pit_dec_unit #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] val,
    input  logic [WIDTH-1:0] init,
    input  logic             bcd,
    output logic [WIDTH-1:0] dec_val,
    output logic [WIDTH-1:0] half_val
);
    localparam int DIGITS = WIDTH / 4;
    localparam logic [WIDTH-1:0] ONE     = WIDTH'(1);
    localparam logic [WIDTH-1:0] BIN_TOP = ONE << (WIDTH - 1);
    localparam logic [WIDTH-1:0] BCD_TOP = WIDTH'(5) << (4 * (DIGITS - 1));

    logic [WIDTH-1:0]  bcd_dec;
    logic [WIDTH-1:0]  bcd_half;
    logic [DIGITS-1:0] brw;

    assign brw[0] = 1'b1;

    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
        logic [3:0] nib;
        logic       hi_odd;
        assign nib = val[4*i +: 4];
        assign bcd_dec[4*i +: 4] = brw[i] ? ((nib == 4'd0) ? 4'd9 : nib - 4'd1) : nib;
        if (i < DIGITS - 1) begin : g_chain
            assign brw[i+1] = brw[i] & (nib == 4'd0);
            assign hi_odd   = init[4*(i+1)];
        end else begin : g_top
            assign hi_odd = 1'b0;
        end
        assign bcd_half[4*i +: 4] = {1'b0, init[4*i+3 : 4*i+1]} + (hi_odd ? 4'd5 : 4'd0);
    end

    always_comb begin
        if (bcd) begin
            dec_val  = bcd_dec;
            half_val = (init == '0) ? BCD_TOP : bcd_half;
        end else begin
            dec_val  = val - ONE;
            half_val = (init == '0) ? BIN_TOP : {1'b0, init[WIDTH-1:1]};
        end
    end
endmodule

// File: rtl/pit_channel.sv
module pit_channel #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic [2:0]       ctrl_mode,
    input  logic             ctrl_bcd,
    input  logic             cnt_we,
    input  logic [WIDTH-1:0] cnt_data,
    input  logic             gate,
    output logic             out
);
    import pit_pkg::*;

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    typedef struct packed {
        mode_e            mode;
        logic             bcd;
        logic [WIDTH-1:0] init;
        logic [WIDTH-1:0] cnt;
        logic             pend;
        logic             have;
        logic             run;
        logic             armed;
        logic             outr;
    } chan_t;

    chan_t st_q, st_d;

    logic             trig;
    logic [WIDTH-1:0] dec_val, half_val, nxt_cnt;
    logic             periodic, trig_start, trig_mode, en, load;

    pit_gate_unit u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .gate  (gate),
        .trig  (trig)
    );

    pit_dec_unit #(.WIDTH(WIDTH)) u_dec (
        .val      (st_q.cnt),
        .init     (st_q.init),
        .bcd      (st_q.bcd),
        .dec_val  (dec_val),
        .half_val (half_val)
    );

    always_comb begin
        periodic   = (st_q.mode == M_RATE) || (st_q.mode == M_SQUARE);
        trig_start = (st_q.mode == M_ONESHOT) || (st_q.mode == M_HWSTROBE);
        trig_mode  = periodic || trig_start;
        en         = trig_start || gate;
        load       = st_q.have && ((st_q.pend && !trig_start) || (trig && trig_mode));
        nxt_cnt    = (periodic && st_q.cnt == ONE) ? st_q.init : dec_val;

        st_d = st_q;
        if (ctrl_we) begin
            st_d.mode  = norm_mode(ctrl_mode);
            st_d.bcd   = ctrl_bcd;
            st_d.pend  = 1'b0;
            st_d.have  = 1'b0;
            st_d.run   = 1'b0;
            st_d.armed = 1'b0;
            st_d.outr  = (norm_mode(ctrl_mode) != M_TERM);
        end else if (cnt_we) begin
            st_d.init = cnt_data;
            st_d.have = 1'b1;
            st_d.pend = 1'b1;
            if (st_q.mode == M_TERM || st_q.mode == M_SWSTROBE) st_d.run = 1'b0;
            if (st_q.mode == M_TERM) st_d.outr = 1'b0;
        end else if (load) begin
            st_d.cnt   = st_q.init;
            st_d.pend  = 1'b0;
            st_d.run   = 1'b1;
            st_d.armed = 1'b1;
            st_d.outr  = !(st_q.mode == M_TERM || st_q.mode == M_ONESHOT);
        end else if (st_q.run && en) begin
            st_d.cnt = nxt_cnt;
            unique case (st_q.mode)
                M_TERM, M_ONESHOT: if (nxt_cnt == '0) st_d.outr = 1'b1;
                M_RATE:            st_d.outr = (nxt_cnt != ONE);
                M_SQUARE:          st_d.outr = (nxt_cnt == '0) || (nxt_cnt > half_val);
                default: begin
                    if (st_q.armed && nxt_cnt == '0) begin
                        st_d.outr  = 1'b0;
                        st_d.armed = 1'b0;
                    end else begin
                        st_d.outr = 1'b1;
                    end
                end
            endcase
        end else if (st_q.mode == M_SWSTROBE || st_q.mode == M_HWSTROBE) begin
            st_d.outr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out = st_q.outr | (periodic & ~gate);

    AST_CTRL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> (!st_q.run && !st_q.pend)); // R2
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mode <= M_HWSTROBE); // R2
    AST_TERM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_TERM && st_q.outr && !ctrl_we && !cnt_we) |=> st_q.outr); // R5
    AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.mode == M_SWSTROBE || st_q.mode == M_HWSTROBE) && !st_q.outr
         && !ctrl_we && !cnt_we) |=> st_q.outr); // R9
    AST_RATE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_RATE && st_q.run && gate && st_q.cnt == ONE
         && !ctrl_we && !cnt_we && !trig) |=> (st_q.cnt == $past(st_q.init))); // R7
endmodule

// File: tb/sim_pit_channel.sv
module sim_pit_channel;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [2:0]  ctrl_mode = 3'd0;
    logic        ctrl_bcd = 1'b0;
    logic        cnt_we = 1'b0;
    logic [15:0] cnt_data = 16'd0;
    logic        gate = 1'b0;
    logic        out;

    int    vec_cnt = 0;
    int    err_cnt = 0;
    string cur_req = "R1";
    bit    exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pit_channel u0 (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_mode(ctrl_mode),
        .ctrl_bcd(ctrl_bcd), .cnt_we(cnt_we), .cnt_data(cnt_data),
        .gate(gate), .out(out)
    );

    task automatic check(input logic act, input logic expv, input string req);
        vec_cnt++;
        if (act !== expv) begin
            err_cnt++;
            $display("FAIL %s: out=%b expected %b at %0t", req, act, expv, $time);
        end
    endtask

    function automatic int bcd2int(input logic [15:0] v);
        return v[15:12]*1000 + v[11:8]*100 + v[7:4]*10 + v[3:0];
    endfunction

    // Reference model: integer count, computed from the requirements.
    int   m_mode = 0, m_init = 0, m_c = 0;
    bit   m_bcd = 0, m_have = 0, m_pend = 0, m_run = 0, m_armed = 0, m_out = 0, m_gprev = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_bcd = 0; m_have = 0; m_pend = 0; m_run = 0;
            m_armed = 0; m_out = 0; m_gprev = 0; m_init = 0; m_c = 0;
        end else begin
            bit trg, en, ld, per, tst;
            int mx, neff;
            trg = gate && !m_gprev;
            m_gprev = gate;
            mx   = m_bcd ? 10000 : 65536;
            neff = (m_init == 0) ? mx : (m_bcd ? bcd2int(16'(m_init)) : m_init);
            per  = (m_mode == 2 || m_mode == 3);
            tst  = (m_mode == 1 || m_mode == 5);
            en   = tst || gate;
            ld   = m_have && ((m_pend && !tst) || (trg && (per || tst)));
            if (ctrl_we) begin
                m_mode = (ctrl_mode >= 6) ? int'(ctrl_mode) - 4 : int'(ctrl_mode);
                m_bcd = ctrl_bcd; m_pend = 0; m_have = 0; m_run = 0; m_armed = 0;
                m_out = (m_mode != 0);
            end else if (cnt_we) begin
                m_init = cnt_data; m_have = 1; m_pend = 1;
                if (m_mode == 0 || m_mode == 4) m_run = 0;
                if (m_mode == 0) m_out = 0;
            end else if (ld) begin
                m_c = neff; m_pend = 0; m_run = 1; m_armed = 1;
                m_out = !(m_mode == 0 || m_mode == 1);
            end else if (m_run && en) begin
                if (per && m_c == 1) m_c = neff;
                else m_c = (m_c == 0) ? mx - 1 : m_c - 1;
                case (m_mode)
                    0, 1: if (m_c == 0) m_out = 1;
                    2:    m_out = (m_c != 1);
                    3:    m_out = (m_c > neff / 2);
                    default: begin
                        if (m_armed && m_c == 0) begin m_out = 0; m_armed = 0; end
                        else m_out = 1;
                    end
                endcase
            end else if (m_mode == 4 || m_mode == 5) begin
                m_out = 1;
            end
            exp_q.push_back(m_out);
        end
    end

    // Monitor: compare away from the active edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic e;
            e = exp_q.pop_front();
            e = e | ((m_mode == 2 || m_mode == 3) && !gate);
            check(out, e, cur_req);
        end
    end

    task automatic wr_ctrl(input int md, input bit bcd);
        @(posedge clk); #1;
        ctrl_we = 1'b1; ctrl_mode = 3'(md); ctrl_bcd = bcd;
        @(posedge clk); #1;
        ctrl_we = 1'b0;
    endtask

    task automatic wr_count(input logic [15:0] v);
        @(posedge clk); #1;
        cnt_we = 1'b1; cnt_data = v;
        @(posedge clk); #1;
        cnt_we = 1'b0;
    endtask

    task automatic set_gate(input bit v);
        @(posedge clk); #1;
        gate = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        err_cnt++;
        $display("FAIL watchdog: out=%b expected run end", out);
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
        $finish;
    end

    initial begin
        cur_req = "R1";
        repeat (2) @(negedge clk);
        check(out, 1'b0, "R1");
        @(posedge clk); #1; rst_n = 1'b1;
        set_gate(1); idle(3); set_gate(0); idle(3);

        cur_req = "R2";                     // alias code 6 acts as rate mode
        set_gate(1); wr_ctrl(6, 0); wr_count(16'd3); idle(10);
        wr_ctrl(1, 0); idle(4);             // one-shot idles high

        cur_req = "R5";
        wr_ctrl(0, 0); wr_count(16'd4); idle(10);
        cur_req = "R4";                     // level gate pauses mode 0
        wr_count(16'd5); idle(2); set_gate(0); idle(4); set_gate(1); idle(8);

        cur_req = "R6";
        wr_ctrl(1, 0); wr_count(16'd4); set_gate(0); idle(2);
        set_gate(1); set_gate(0); idle(8);
        set_gate(1); set_gate(0); idle(2);  // retrigger mid-pulse
        set_gate(1); set_gate(0); idle(8);

        cur_req = "R7";
        set_gate(1); wr_ctrl(2, 0); wr_count(16'd4); idle(14);
        cur_req = "R10";
        set_gate(0); idle(3); set_gate(1); idle(10);

        cur_req = "R8";
        wr_ctrl(3, 0); wr_count(16'd5); idle(20);
        wr_count(16'd6); idle(20);
        set_gate(0); idle(2); set_gate(1); idle(8);

        cur_req = "R9";
        wr_ctrl(4, 0); wr_count(16'd3); idle(10);
        wr_ctrl(5, 0); wr_count(16'd3); set_gate(0); idle(2);
        set_gate(1); idle(10);

        cur_req = "R11";
        wr_ctrl(2, 1); wr_count(16'h0012); idle(30);
        wr_ctrl(3, 1); wr_count(16'h0100); idle(250);
        wr_ctrl(3, 0); wr_count(16'h0100); idle(300);

        cur_req = "R2";                     // control write stops a running count
        wr_ctrl(0, 0); wr_count(16'd6); idle(2); wr_ctrl(0, 0); idle(12);

        cur_req = "R3";                     // zero count means full range
        wr_ctrl(0, 1); wr_count(16'h0000); idle(10005);
        wr_ctrl(0, 0); wr_count(16'h0000); idle(65540);

        idle(2);
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
        $finish;
    end
endmodule